// File: doc/BRIEF.md
# Binary Calendar Clock with Two Weekday Alarms and a Periodic Interrupt

This block keeps wall-clock time in plain binary fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A free-running sub-second divider, clocked at 32768 Hz by default, produces one increment per second. It also produces pulse taps at twice and four times that rate. The calendar steps through month lengths and leap Februaries without software help. When the bus chip select is high, an increment that falls due is parked and applied once the select drops, so a multi-byte read never sees a carry in mid-access.

Two identical alarms each compare an hour, a minute and a seven-bit weekday mask against the running time. A match at second zero raises a sticky flag. A periodic interrupt source can follow the 2 Hz or 1 Hz pulse directly, or latch once per minute, hour or month. Software reaches all state through a single-cycle write strobe port and a combinational read port. Register addresses: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 7/8/9 alarm A minute/hour/mask, 10/11/12 alarm B minute/hour/mask, 13 control, 14 status.

Top module: `rtc_calendar_top`

## Requirements
- R1: After reset the time reads 00:00:00, weekday 0, day 1, month 1, year 0. All three interrupt outputs are low, and control (address 13) reads 0x1C, which means both alarms are off and periodic select is 7 (none).
- R2: Each increment advances seconds. Seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, and hours wrap from 23 to 0.
- R3: At the hour wrap the weekday advances and wraps from 6 to 0. The day wraps to 1 after 30 in months 4, 6, 9 and 11, and after 31 in all other months except February. Month 12 wraps to 1, and year 99 wraps to 0.
- R4: February has 29 days when the year value is a multiple of 4, with year 0 counted as leap, and 28 days otherwise.
- R5: A write to seconds (address 0) clears the sub-second divider, so the next increment lands exactly 2^PRE_W clock cycles after that write.
- R6: While cs is high no increment is applied. One due increment is held and is applied on the first cycle with cs low, and a second increment that falls due while cs is still high is not added.
- R7: When an alarm is enabled (control bit 0 for A, bit 1 for B), its flag goes high one cycle after the increment that produces second 0 with the alarm's hour and minute. The mask bit indexed by the weekday value must also be set. Flags are visible on alarm_a_irq and alarm_b_irq.
- R8: A flag stays low when its alarm is disabled or its mask bit for the current weekday is clear. Writing 1 to status bit 0 (A) or bit 1 (B) clears the flag, and a write of 0 is not needed.
- R9: Periodic select (control bits 4:2) code 0 drives periodic_irq with the 2 Hz pulse and code 1 with the one-cycle increment pulse. Status writes have no effect on these two modes.
- R10: Select codes 2, 3 and 4 latch periodic_irq at second 0 of a new minute, at minute 0 of a new hour, and at 00:00:00 on day 1, in that order. Writing 1 to status bit 2 clears the latch.
- R11: tap_2hz pulses for one cycle twice per second and tap_4hz four times per second, both from the same divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time base, 32768 Hz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Bus select; holds off increments while high |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| alarm_a_irq | output | 1 | Alarm A sticky flag |
| alarm_b_irq | output | 1 | Alarm B sticky flag |
| periodic_irq | output | 1 | Periodic interrupt, pulse or latched by select |
| tap_2hz | output | 1 | One-cycle pulse at twice per second |
| tap_4hz | output | 1 | One-cycle pulse at four times per second |

## Verification
A write to seconds sets the divider to zero on that edge. The calendar then changes on the 2^PRE_W-th following edge, and the bench runs with PRE_W = 4, so that is edge 16. Alarm flags and the minute, hour and month latch follow one edge later, because they look at the registered increment. The bench therefore samples the unchanged time after edge 15, the new time after edge 16, and the flags after edge 20, always at the falling edge. Tap and pulse counts are taken over exactly 32 falling edges after a seconds write, and a parked increment is read on the first edge after cs falls, before the next one can be due.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FW = 8;
  typedef logic [FW-1:0] field_t;

  localparam logic [3:0] A_SEC   = 4'd0;
  localparam logic [3:0] A_MIN   = 4'd1;
  localparam logic [3:0] A_HOUR  = 4'd2;
  localparam logic [3:0] A_WDAY  = 4'd3;
  localparam logic [3:0] A_DAY   = 4'd4;
  localparam logic [3:0] A_MON   = 4'd5;
  localparam logic [3:0] A_YEAR  = 4'd6;
  localparam logic [3:0] A_ALM0  = 4'd7;   // alarm A base, B at +3
  localparam logic [3:0] A_CTRL  = 4'd13;
  localparam logic [3:0] A_STAT  = 4'd14;

  localparam int ALARMS = 2;

  function automatic field_t month_len(input field_t mon, input field_t year);
    case (mon)
      8'd2:                    month_len = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: month_len = 8'd30;
      default:                 month_len = 8'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic sec_stb,
  output logic half_stb,
  output logic quarter_stb
);
  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign sec_stb     = &cnt_q;
  assign half_stb    = &cnt_q[PRE_W-2:0];
  assign quarter_stb = &cnt_q[PRE_W-3:0];

  // R5
  prescaler_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_stb && !clr) |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  field_t     wr_data,
  output field_t     sec,
  output field_t     min,
  output field_t     hour,
  output field_t     wday,
  output field_t     day,
  output field_t     mon,
  output field_t     year
);
  field_t sec_d, min_d, hour_d, wday_d, day_d, mon_d, year_d;
  logic   cal_wr;

  assign cal_wr = wr_en && (wr_addr <= A_YEAR);

  always_comb begin
    sec_d = sec; min_d = min; hour_d = hour; wday_d = wday;
    day_d = day; mon_d = mon; year_d = year;
    if (cal_wr) begin
      case (wr_addr)
        A_SEC:   sec_d  = wr_data;
        A_MIN:   min_d  = wr_data;
        A_HOUR:  hour_d = wr_data;
        A_WDAY:  wday_d = wr_data;
        A_DAY:   day_d  = wr_data;
        A_MON:   mon_d  = wr_data;
        default: year_d = wr_data;
      endcase
    end else if (inc) begin
      if (sec != 8'd59) sec_d = sec + 8'd1;
      else begin
        sec_d = '0;
        if (min != 8'd59) min_d = min + 8'd1;
        else begin
          min_d = '0;
          if (hour != 8'd23) hour_d = hour + 8'd1;
          else begin
            hour_d = '0;
            wday_d = (wday >= 8'd6) ? 8'd0 : wday + 8'd1;
            if (day < month_len(mon, year)) day_d = day + 8'd1;
            else begin
              day_d = 8'd1;
              if (mon < 8'd12) mon_d = mon + 8'd1;
              else begin
                mon_d  = 8'd1;
                year_d = (year >= 8'd99) ? 8'd0 : year + 8'd1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec <= '0; min <= '0; hour <= '0; wday <= '0;
      day <= 8'd1; mon <= 8'd1; year <= '0;
    end else begin
      sec <= sec_d; min <= min_d; hour <= hour_d; wday <= wday_d;
      day <= day_d; mon <= mon_d; year <= year_d;
    end
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ld_min,
  input  logic   ld_hour,
  input  logic   ld_mask,
  input  field_t wr_data,
  input  logic   en,
  input  logic   check,
  input  logic   clr,
  input  field_t cur_min,
  input  field_t cur_hour,
  input  field_t cur_wday,
  output field_t cfg_min,
  output field_t cfg_hour,
  output logic [6:0] cfg_mask,
  output logic   flag
);
  logic hit, day_ok, flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_min <= '0; cfg_hour <= '0; cfg_mask <= '0;
    end else begin
      if (ld_min)  cfg_min  <= wr_data;
      if (ld_hour) cfg_hour <= wr_data;
      if (ld_mask) cfg_mask <= wr_data[6:0];
    end
  end

  assign day_ok = (cur_wday < 8'd7) && cfg_mask[cur_wday[2:0]];
  assign hit    = en && check && day_ok &&
                  (cur_min == cfg_min) && (cur_hour == cfg_hour);

  always_comb begin
    flag_d = flag;
    if (clr) flag_d = 1'b0;
    if (hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end

  // R7
  alarm_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(en));
  // R8
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag);
endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
  import rtc_pkg::*;
#(
  parameter int PRE_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       alarm_a_irq,
  output logic       alarm_b_irq,
  output logic       periodic_irq,
  output logic       tap_2hz,
  output logic       tap_4hz
);
  localparam logic [7:0] CTRL_RST = 8'h1C;

  logic   sec_stb, sec_wr, inc, inc_q, pend_q, pend_d;
  field_t sec, min, hour, wday, day, mon, year;
  logic [4:0] ctrl_q;
  logic [2:0] psel;
  logic   min_evt, hour_evt, mon_evt, pset, pclr, pflag_q, pflag_d;
  logic   stat_wr;
  field_t al_min  [ALARMS];
  field_t al_hour [ALARMS];
  logic [6:0] al_mask [ALARMS];
  logic   al_flag [ALARMS];

  assign sec_wr  = wr_en && (wr_addr == A_SEC);
  assign stat_wr = wr_en && (wr_addr == A_STAT);

  rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(sec_wr),
    .sec_stb(sec_stb), .half_stb(tap_2hz), .quarter_stb(tap_4hz));

  // increment hold-off while the bus is selected
  assign inc = !cs && (sec_stb || pend_q);

  always_comb begin
    pend_d = 1'b0;
    if (cs && !sec_wr) pend_d = pend_q || sec_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0; inc_q <= 1'b0;
    end else begin
      pend_q <= pend_d; inc_q <= inc;
    end
  end

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .inc(inc), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec(sec), .min(min), .hour(hour), .wday(wday),
    .day(day), .mon(mon), .year(year));

  assign min_evt  = inc_q && (sec == '0);
  assign hour_evt = min_evt && (min == '0);
  assign mon_evt  = hour_evt && (hour == '0) && (day == 8'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ctrl_q <= CTRL_RST[4:0];
    else if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data[4:0];
  end
  assign psel = ctrl_q[4:2];

  genvar g;
  generate
    for (g = 0; g < ALARMS; g++) begin : g_alarm
      localparam logic [3:0] BASE = A_ALM0 + 4'(3 * g);
      rtc_alarm u_alarm (
        .clk(clk), .rst_n(rst_n),
        .ld_min (wr_en && wr_addr == BASE),
        .ld_hour(wr_en && wr_addr == BASE + 4'd1),
        .ld_mask(wr_en && wr_addr == BASE + 4'd2),
        .wr_data(wr_data), .en(ctrl_q[g]), .check(min_evt),
        .clr(stat_wr && wr_data[g]),
        .cur_min(min), .cur_hour(hour), .cur_wday(wday),
        .cfg_min(al_min[g]), .cfg_hour(al_hour[g]), .cfg_mask(al_mask[g]),
        .flag(al_flag[g]));
    end
  endgenerate

  assign alarm_a_irq = al_flag[0];
  assign alarm_b_irq = al_flag[1];

  always_comb begin
    case (psel)
      3'd2:    pset = min_evt;
      3'd3:    pset = hour_evt;
      3'd4:    pset = mon_evt;
      default: pset = 1'b0;
    endcase
  end
  assign pclr = stat_wr && wr_data[2];

  always_comb begin
    pflag_d = pflag_q;
    if (pclr) pflag_d = 1'b0;
    if (pset) pflag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pflag_q <= 1'b0;
    else        pflag_q <= pflag_d;
  end

  always_comb begin
    case (psel)
      3'd0:    periodic_irq = tap_2hz;
      3'd1:    periodic_irq = inc;
      default: periodic_irq = pflag_q;
    endcase
  end

  always_comb begin
    case (rd_addr)
      A_SEC:   rd_data = sec;
      A_MIN:   rd_data = min;
      A_HOUR:  rd_data = hour;
      A_WDAY:  rd_data = wday;
      A_DAY:   rd_data = day;
      A_MON:   rd_data = mon;
      A_YEAR:  rd_data = year;
      4'd7:    rd_data = al_min[0];
      4'd8:    rd_data = al_hour[0];
      4'd9:    rd_data = {1'b0, al_mask[0]};
      4'd10:   rd_data = al_min[1];
      4'd11:   rd_data = al_hour[1];
      4'd12:   rd_data = {1'b0, al_mask[1]};
      A_CTRL:  rd_data = {3'b000, ctrl_q};
      A_STAT:  rd_data = {5'b00000, pflag_q, al_flag[1], al_flag[0]};
      default: rd_data = '0;
    endcase
  end

  // R6
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !(wr_en && wr_addr <= A_YEAR)) |=> $stable(sec));
  // R10
  periodic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pclr && !pset) |=> !pflag_q);
endmodule

// File: tb/rtc_calendar_top_bench.sv
module rtc_calendar_top_bench;
  localparam int PRE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic alarm_a_irq, alarm_b_irq, periodic_irq, tap_2hz, tap_4hz;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rtc_calendar_top #(.PRE_W(PRE_W)) u_rtc_calendar_top (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_a_irq(alarm_a_irq), .alarm_b_irq(alarm_b_irq),
    .periodic_irq(periodic_irq), .tap_2hz(tap_2hz), .tap_4hz(tap_4hz));

  // {sec,min,hour,wday,day,mon,year} before, then expected after one increment
  localparam logic [111:0] VEC [8] = '{
    {8'd30,8'd20,8'd10,8'd2,8'd5, 8'd3, 8'd21,  8'd31,8'd20,8'd10,8'd2,8'd5, 8'd3, 8'd21},
    {8'd59,8'd59,8'd23,8'd6,8'd31,8'd12,8'd99,  8'd0, 8'd0, 8'd0, 8'd0,8'd1, 8'd1, 8'd0 },
    {8'd59,8'd59,8'd23,8'd1,8'd28,8'd2, 8'd23,  8'd0, 8'd0, 8'd0, 8'd2,8'd1, 8'd3, 8'd23},
    {8'd59,8'd59,8'd23,8'd1,8'd28,8'd2, 8'd24,  8'd0, 8'd0, 8'd0, 8'd2,8'd29,8'd2, 8'd24},
    {8'd59,8'd59,8'd23,8'd3,8'd29,8'd2, 8'd0,   8'd0, 8'd0, 8'd0, 8'd4,8'd1, 8'd3, 8'd0 },
    {8'd59,8'd59,8'd23,8'd5,8'd30,8'd4, 8'd5,   8'd0, 8'd0, 8'd0, 8'd6,8'd1, 8'd5, 8'd5 },
    {8'd59,8'd59,8'd23,8'd6,8'd30,8'd7, 8'd10,  8'd0, 8'd0, 8'd0, 8'd0,8'd31,8'd7, 8'd10},
    {8'd59,8'd59,8'd12,8'd0,8'd15,8'd6, 8'd30,  8'd0, 8'd0, 8'd13,8'd0,8'd15,8'd6, 8'd30}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic read_time(output logic [55:0] t);
    logic [7:0] v;
    for (int i = 0; i < 7; i++) begin
      rd(4'(i), v);
      t[55-8*i -: 8] = v;
    end
  endtask

  task automatic set_time(input logic [55:0] t);
    for (int i = 1; i < 7; i++) wr(4'(i), t[55-8*i -: 8]);
    wr(4'd0, t[55:48]);   // seconds last: divider restarts here
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [55:0] t;
    logic [7:0]  v;
    int n1, n2, n4;

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    read_time(t);
    check("R1 time", t, {8'd0,8'd0,8'd0,8'd0,8'd1,8'd1,8'd0});
    rd(4'd13, v);
    check("R1 control", v, 8'h1C);
    check("R1 irqs", {alarm_a_irq, alarm_b_irq, periodic_irq}, 3'b000);

    // R2 R3 R4 vector table
    for (int k = 0; k < 8; k++) begin
      set_time(VEC[k][111:56]);
      repeat (18) @(posedge clk);
      @(negedge clk);
      read_time(t);
      check($sformatf("R2/R3/R4 vector %0d", k), t, VEC[k][55:0]);
    end

    // R5 divider restart on seconds write
    wr(4'd0, 8'd0);
    repeat (15) @(posedge clk);
    @(negedge clk); rd(4'd0, v);
    check("R5 before edge 16", v, 8'd0);
    @(posedge clk); @(negedge clk); rd(4'd0, v);
    check("R5 at edge 16", v, 8'd1);

    // R6 hold-off while selected, only one held increment
    wr(4'd0, 8'd5);
    cs = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk); rd(4'd0, v);
    check("R6 held", v, 8'd5);
    cs = 1'b0;
    @(posedge clk); @(negedge clk); rd(4'd0, v);
    check("R6 released", v, 8'd6);

    // R7 R8 alarms: A matches 10:21 on weekday 2, B masked to weekday 0
    wr(4'd7, 8'd21); wr(4'd8, 8'd10); wr(4'd9, 8'h04);
    wr(4'd10, 8'd21); wr(4'd11, 8'd10); wr(4'd12, 8'h01);
    wr(4'd13, 8'h1F);
    set_time({8'd59,8'd20,8'd10,8'd2,8'd5,8'd3,8'd21});
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R7 alarm A set", alarm_a_irq, 1'b1);
    check("R8 alarm B mask miss", alarm_b_irq, 1'b0);
    wr(4'd14, 8'h01);
    check("R8 alarm A cleared", alarm_a_irq, 1'b0);
    wr(4'd13, 8'h1C);   // alarms off
    set_time({8'd59,8'd20,8'd10,8'd2,8'd5,8'd3,8'd21});
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R8 alarm A disabled", alarm_a_irq, 1'b0);

    // R9 R11 pulse mode 1 Hz with status writes, and taps
    wr(4'd13, 8'h04);   // select 1
    wr(4'd0, 8'd0);
    n1 = 0; n2 = 0; n4 = 0;
    wr_en = 1'b1; wr_addr = 4'd14; wr_data = 8'h07;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      n1 += int'(periodic_irq); n2 += int'(tap_2hz); n4 += int'(tap_4hz);
    end
    wr_en = 1'b0;
    check("R9 1 Hz pulses despite clear", n1, 2);
    check("R11 2 Hz taps", n2, 4);
    check("R11 4 Hz taps", n4, 8);

    // R10 latched minute and hour events
    wr(4'd13, 8'h08);   // select 2
    set_time({8'd59,8'd5,8'd3,8'd1,8'd9,8'd9,8'd9});
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R10 minute latch", periodic_irq, 1'b1);
    wr(4'd14, 8'h04);
    check("R10 minute cleared", periodic_irq, 1'b0);
    wr(4'd13, 8'h0C);   // select 3
    set_time({8'd59,8'd20,8'd10,8'd1,8'd9,8'd9,8'd9});
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R10 no hour event", periodic_irq, 1'b0);
    set_time({8'd59,8'd59,8'd10,8'd1,8'd9,8'd9,8'd9});
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R10 hour latch", periodic_irq, 1'b1);

    finish_run();
  end
endmodule